// File: doc/BRIEF.md
# Coherent 16-bit channel value buffer

This block sits between a byte-wide register bus and the 16-bit compare/capture value of one timer channel. Software writes the high and low bytes one at a time. The block holds them in a buffer. Only after both halves have arrived does it pass the pair on as a single 16-bit value. The moment the pair reaches the active channel register depends on the timer state. When the counter clock is off, the update is immediate. In output-compare mode it waits for the next counter step. In either PWM mode it waits for the step into the modulo value. The timer therefore never acts on a half-written value.

Reads are made coherent in the same way. Reading either byte first takes a snapshot of the other byte, and the next read of that other byte returns the snapshot. A debug-freeze input stops all latch bookkeeping. During freeze, value writes go straight into the active register and reads return the live value. A buffered sequence that was half finished before freeze therefore completes normally afterwards. A write to the channel's control register clears both latch states.

Top module: `cvb_chan_buffer`

## Requirements
- R1: High (`wr_hi`) and low (`wr_lo`) byte writes may arrive in either order. The active value `chan_val` changes only after both halves have been written since the last completion or clear.
- R2: When `clk_sel` is 2'b00 (counter clock off), a completed pair appears on `chan_val` right after the clock edge that samples the second byte write.
- R3: When `clk_sel` is not 2'b00 and `mode` is 2'b01 (output compare), a completed pair is held pending. It moves to `chan_val` at the first clock edge where `cnt_tick` is high, counting from the cycle after the completing write.
- R4: When `clk_sel` is not 2'b00 and `mode` is 2'b10 (edge PWM) or 2'b11 (center PWM), the pending pair moves at an edge where `cnt_tick` is high and `cnt_val` equals `mod_val` minus 1. A `mod_val` of zero means a free-running counter, so the transfer happens on the tick at 16'hFFFE.
- R5: A newer completed pair replaces a pending pair that has not yet been transferred.
- R6: A pulse on `ctl_wr` clears the write-latch state and the read-latch state, also during freeze. A value write in the same cycle is ignored.
- R7: When `mode` is 2'b00 (input capture), value byte writes are ignored, also during freeze.
- R8: While `freeze` is high, a value byte write goes directly into its byte of `chan_val` on the next edge. The buffered bytes and the half-written state are kept. After freeze ends, completing the sequence applies the bytes buffered before freeze.
- R9: A read of either byte while no snapshot is held returns the live byte and snapshots the other byte. A following read of that other byte returns the snapshot and releases it. A repeated read of the first byte returns live data and takes a new snapshot. `rd_hi` wins if both strobes are high.
- R10: While `freeze` is high, reads return the live bytes of `chan_val`, and the read snapshot state is left unchanged.
- R11: Reset clears `chan_val`, both buffers, the pending pair and both latch states to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_hi | input | 1 | High value byte write strobe |
| wr_lo | input | 1 | Low value byte write strobe |
| wr_data | input | BYTE_W | Write data byte |
| rd_hi | input | 1 | High value byte read strobe |
| rd_lo | input | 1 | Low value byte read strobe |
| rd_data | output | BYTE_W | Read data, valid in the strobe cycle |
| freeze | input | 1 | Debug freeze |
| ctl_wr | input | 1 | Channel control register write strobe |
| clk_sel | input | 2 | Counter clock source, 2'b00 = off |
| mode | input | 2 | Channel mode: 00 capture, 01 compare, 10 edge PWM, 11 center PWM |
| cnt_val | input | 2*BYTE_W | Current counter value |
| mod_val | input | 2*BYTE_W | Modulo value, zero = free-running |
| cnt_tick | input | 1 | Counter steps on this edge |
| chan_val | output | 2*BYTE_W | Active channel value |

## Verification
The bench builds the block with the default byte width of 8, which gives a 16-bit value. It drives the counter and modulo inputs directly, so the free-running step from 16'hFFFE to 16'hFFFF can be reached at once without counting up. It also checks the wrap tick at the modulo value itself, which must not cause a transfer. The read-latch tests change the live value between the two halves of a read, so that a snapshot and a live byte give different results.

// File: rtl/cvb_pkg.sv
package cvb_pkg;

    typedef enum logic [1:0] {
        CH_CAPTURE    = 2'b00,
        CH_COMPARE    = 2'b01,
        CH_EDGE_PWM   = 2'b10,
        CH_CENTER_PWM = 2'b11
    } ch_mode_e;

    localparam logic [1:0] CLK_OFF = 2'b00;

endpackage

// File: rtl/cvb_wr_seq.sv
module cvb_wr_seq #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  freeze,
    input  logic                  ctl_wr,
    input  logic                  capture,
    output logic                  pair_done,
    output logic [2*BYTE_W-1:0]   pair_val,
    output logic                  hi_seen,
    output logic                  lo_seen
);
    typedef struct packed {
        logic              hi_seen;
        logic              lo_seen;
        logic [BYTE_W-1:0] hi_buf;
        logic [BYTE_W-1:0] lo_buf;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      accept;

    always_comb begin
        s_d       = s_q;
        pair_done = 1'b0;
        accept    = !freeze && !capture && !ctl_wr;
        if (ctl_wr) begin
            s_d.hi_seen = 1'b0;
            s_d.lo_seen = 1'b0;
        end else if (accept) begin
            if (wr_hi) begin
                s_d.hi_buf  = wr_data;
                s_d.hi_seen = 1'b1;
            end
            if (wr_lo) begin
                s_d.lo_buf  = wr_data;
                s_d.lo_seen = 1'b1;
            end
            if (s_d.hi_seen && s_d.lo_seen) begin
                pair_done   = 1'b1;
                s_d.hi_seen = 1'b0;
                s_d.lo_seen = 1'b0;
            end
        end
        pair_val = {s_d.hi_buf, s_d.lo_buf};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hi_seen = s_q.hi_seen;
    assign lo_seen = s_q.lo_seen;

endmodule

// File: rtl/cvb_xfer.sv
module cvb_xfer
    import cvb_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pair_done,
    input  logic [VAL_W-1:0] pair_val,
    input  logic [1:0]       clk_sel,
    input  logic [1:0]       mode,
    input  logic [VAL_W-1:0] cnt_val,
    input  logic [VAL_W-1:0] mod_val,
    input  logic             cnt_tick,
    output logic             load,
    output logic [VAL_W-1:0] load_val,
    output logic             pend_valid
);
    typedef struct packed {
        logic             pend_valid;
        logic [VAL_W-1:0] pend_val;
    } xf_state_t;

    xf_state_t        s_d, s_q;
    logic             stopped, is_pwm, pwm_hit, upd_evt;
    logic [VAL_W-1:0] top_val;

    always_comb begin
        stopped  = (clk_sel == CLK_OFF);
        is_pwm   = (ch_mode_e'(mode) == CH_EDGE_PWM) || (ch_mode_e'(mode) == CH_CENTER_PWM);
        top_val  = (mod_val == '0) ? '1 : mod_val;
        pwm_hit  = cnt_tick && (cnt_val == (top_val - VAL_W'(1)));
        upd_evt  = stopped || (is_pwm ? pwm_hit : cnt_tick);

        s_d      = s_q;
        load     = 1'b0;
        load_val = s_q.pend_val;
        if (s_q.pend_valid && upd_evt) begin
            load           = 1'b1;
            s_d.pend_valid = 1'b0;
        end
        if (pair_done) begin
            if (stopped) begin
                load           = 1'b1;
                load_val       = pair_val;
                s_d.pend_valid = 1'b0;
            end else begin
                s_d.pend_val   = pair_val;
                s_d.pend_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_valid = s_q.pend_valid;

endmodule

// File: rtl/cvb_rd_latch.sv
module cvb_rd_latch #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_hi,
    input  logic                rd_lo,
    input  logic                freeze,
    input  logic                ctl_wr,
    input  logic [2*BYTE_W-1:0] live_val,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                armed
);
    localparam int VAL_W = 2 * BYTE_W;

    typedef struct packed {
        logic              armed;
        logic              hi_first;
        logic [BYTE_W-1:0] snap;
    } rd_state_t;

    rd_state_t         s_d, s_q;
    logic [BYTE_W-1:0] live_hi, live_lo;

    always_comb begin
        live_hi = live_val[VAL_W-1:BYTE_W];
        live_lo = live_val[BYTE_W-1:0];
        s_d     = s_q;
        rd_data = '0;
        if (rd_hi) begin
            if (freeze) begin
                rd_data = live_hi;
            end else if (s_q.armed && !s_q.hi_first) begin
                rd_data   = s_q.snap;
                s_d.armed = 1'b0;
            end else begin
                rd_data      = live_hi;
                s_d.armed    = 1'b1;
                s_d.hi_first = 1'b1;
                s_d.snap     = live_lo;
            end
        end else if (rd_lo) begin
            if (freeze) begin
                rd_data = live_lo;
            end else if (s_q.armed && s_q.hi_first) begin
                rd_data   = s_q.snap;
                s_d.armed = 1'b0;
            end else begin
                rd_data      = live_lo;
                s_d.armed    = 1'b1;
                s_d.hi_first = 1'b0;
                s_d.snap     = live_hi;
            end
        end
        if (ctl_wr) s_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign armed = s_q.armed;

endmodule

// File: rtl/cvb_chan_buffer.sv
module cvb_chan_buffer
    import cvb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_hi,
    input  logic                rd_lo,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic                freeze,
    input  logic                ctl_wr,
    input  logic [1:0]          clk_sel,
    input  logic [1:0]          mode,
    input  logic [2*BYTE_W-1:0] cnt_val,
    input  logic [2*BYTE_W-1:0] mod_val,
    input  logic                cnt_tick,
    output logic [2*BYTE_W-1:0] chan_val
);
    localparam int VAL_W   = 2 * BYTE_W;
    localparam int N_LANES = 2;

    logic             capture, direct_ok;
    logic             pair_done, load, pend_valid;
    logic             hi_seen, lo_seen, rd_armed;
    logic [VAL_W-1:0] pair_val, load_val;
    logic [VAL_W-1:0] chan_d, chan_q;
    logic [N_LANES-1:0] lane_wr;

    assign capture   = (ch_mode_e'(mode) == CH_CAPTURE);
    assign direct_ok = freeze && !capture && !ctl_wr;
    assign lane_wr   = {wr_hi, wr_lo};

    cvb_wr_seq #(.BYTE_W(BYTE_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_data  (wr_data),
        .freeze   (freeze),
        .ctl_wr   (ctl_wr),
        .capture  (capture),
        .pair_done(pair_done),
        .pair_val (pair_val),
        .hi_seen  (hi_seen),
        .lo_seen  (lo_seen)
    );

    cvb_xfer #(.VAL_W(VAL_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_done (pair_done),
        .pair_val  (pair_val),
        .clk_sel   (clk_sel),
        .mode      (mode),
        .cnt_val   (cnt_val),
        .mod_val   (mod_val),
        .cnt_tick  (cnt_tick),
        .load      (load),
        .load_val  (load_val),
        .pend_valid(pend_valid)
    );

    cvb_rd_latch #(.BYTE_W(BYTE_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hi   (rd_hi),
        .rd_lo   (rd_lo),
        .freeze  (freeze),
        .ctl_wr  (ctl_wr),
        .live_val(chan_q),
        .rd_data (rd_data),
        .armed   (rd_armed)
    );

    always_comb begin
        chan_d = load ? load_val : chan_q;
        for (int ln = 0; ln < N_LANES; ln++) begin
            if (direct_ok && lane_wr[ln]) chan_d[ln*BYTE_W +: BYTE_W] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign chan_val = chan_q;

endmodule

// File: rtl/cvb_chan_buffer_chk.sv
module cvb_chan_buffer_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                freeze,
    input logic                ctl_wr,
    input logic [1:0]          clk_sel,
    input logic [1:0]          mode,
    input logic [2*BYTE_W-1:0] cnt_val,
    input logic [2*BYTE_W-1:0] mod_val,
    input logic                cnt_tick,
    input logic [2*BYTE_W-1:0] chan_val,
    input logic                hi_seen,
    input logic                lo_seen,
    input logic                rd_armed,
    input logic                pend_valid
);
    localparam int VAL_W = 2 * BYTE_W;

    logic [VAL_W-1:0] chk_top;
    assign chk_top = (mod_val == '0) ? '1 : mod_val;

    // R1: the two half flags never stand set together between cycles
    a_r1_no_double_half: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_seen && lo_seen));

    // R3: compare mode with running clock changes only on a tick or in freeze
    a_r3_compare_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != 2'b00 && mode == 2'b01 && !cnt_tick && !freeze) |=> $stable(chan_val));

    // R4: PWM modes with running clock change only on the step into the modulo value
    a_r4_pwm_waits_modulo: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != 2'b00 && mode[1] && !freeze &&
         !(cnt_tick && cnt_val == chk_top - VAL_W'(1))) |=> $stable(chan_val));

    // R6: a control write clears every latch flag
    a_r6_ctl_clears_latches: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (!hi_seen && !lo_seen && !rd_armed));

    // R7: capture mode with nothing pending leaves the value alone
    a_r7_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !pend_valid) |=> $stable(chan_val));

    // R8: R10: freeze keeps the latch state
    a_r8_freeze_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !ctl_wr) |=> ($stable(hi_seen) && $stable(lo_seen) && $stable(rd_armed)));

endmodule

bind cvb_chan_buffer cvb_chan_buffer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .ctl_wr    (ctl_wr),
    .clk_sel   (clk_sel),
    .mode      (mode),
    .cnt_val   (cnt_val),
    .mod_val   (mod_val),
    .cnt_tick  (cnt_tick),
    .chan_val  (chan_val),
    .hi_seen   (hi_seen),
    .lo_seen   (lo_seen),
    .rd_armed  (rd_armed),
    .pend_valid(pend_valid)
);

// File: tb/cvb_chan_buffer_test.sv
module cvb_chan_buffer_test;
    localparam int BW     = 8;
    localparam int VW     = 2 * BW;
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_hi = 0, wr_lo = 0, rd_hi = 0, rd_lo = 0;
    logic [BW-1:0] wr_data = '0;
    logic [BW-1:0] rd_data;
    logic          freeze = 0, ctl_wr = 0, cnt_tick = 0;
    logic [1:0]    clk_sel = 2'b00, mode = 2'b01;
    logic [VW-1:0] cnt_val = '0, mod_val = '0;
    logic [VW-1:0] chan_val;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_rd;
        logic [VW-1:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    cvb_chan_buffer #(.BYTE_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data), .freeze(freeze),
        .ctl_wr(ctl_wr), .clk_sel(clk_sel), .mode(mode), .cnt_val(cnt_val),
        .mod_val(mod_val), .cnt_tick(cnt_tick), .chan_val(chan_val)
    );

    always #(PERIOD/2) clk = ~clk;

    // monitor: pops expectations and compares against the outputs
    initial begin
        item_t it;
        logic [VW-1:0] act;
        forever begin
            wait (sb_q.size() != 0);
            #1;
            it = sb_q.pop_front();
            act = it.is_rd ? {{BW{1'b0}}, rd_data} : chan_val;
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_chan(input logic [VW-1:0] exp, input string tag);
        item_t it;
        it.is_rd = 0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        #2;
    endtask

    task automatic wr(input bit hi, input logic [BW-1:0] d);
        wr_hi = hi; wr_lo = !hi; wr_data = d;
        step();
        wr_hi = 0; wr_lo = 0;
    endtask

    task automatic rd(input bit hi, input logic [BW-1:0] exp, input string tag);
        item_t it;
        rd_hi = hi; rd_lo = !hi;
        it.is_rd = 1; it.exp = {{BW{1'b0}}, exp}; it.tag = tag;
        sb_q.push_back(it);
        #2;
        step();
        rd_hi = 0; rd_lo = 0;
    endtask

    task automatic tick(input logic [VW-1:0] c);
        cnt_val = c; cnt_tick = 1;
        step();
        cnt_tick = 0;
    endtask

    task automatic ctl();
        ctl_wr = 1;
        step();
        ctl_wr = 0;
    endtask

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        step();
        chk_chan(16'h0000, "R11 reset value");
        rd(1, 8'h00, "R11 reset read high");

        // R2 clock off, high then low
        clk_sel = 2'b00; mode = 2'b01;
        wr(1, 8'h12);
        chk_chan(16'h0000, "R1 half write held");
        wr(0, 8'h34);
        chk_chan(16'h1234, "R2 immediate update");
        // R1 reverse order
        wr(0, 8'hCD);
        chk_chan(16'h1234, "R1 low first held");
        wr(1, 8'hAB);
        chk_chan(16'hABCD, "R1 low then high");

        // R3 compare, running clock
        clk_sel = 2'b01;
        wr(1, 8'h55); wr(0, 8'h66);
        chk_chan(16'hABCD, "R3 pending before tick");
        tick(16'h0123);
        chk_chan(16'h5566, "R3 update on tick");
        // R5 overwrite pending
        wr(1, 8'h01); wr(0, 8'h02);
        wr(1, 8'h03); wr(0, 8'h04);
        chk_chan(16'h5566, "R5 still pending");
        tick(16'h0010);
        chk_chan(16'h0304, "R5 newer pair wins");

        // R4 edge PWM
        mode = 2'b10; mod_val = 16'h0100;
        wr(1, 8'h77); wr(0, 8'h88);
        tick(16'h0050);
        chk_chan(16'h0304, "R4 tick off modulo");
        tick(16'h0100);
        chk_chan(16'h0304, "R4 tick at modulo");
        tick(16'h00FF);
        chk_chan(16'h7788, "R4 step into modulo");
        // R4 free running
        mod_val = 16'h0000;
        wr(1, 8'h99); wr(0, 8'hAA);
        tick(16'h00FF);
        chk_chan(16'h7788, "R4 free running early tick");
        tick(16'hFFFE);
        chk_chan(16'h99AA, "R4 free running FFFE step");
        // R4 center PWM
        mode = 2'b11; mod_val = 16'h0010;
        wr(1, 8'h42); wr(0, 8'h43);
        tick(16'h0005);
        chk_chan(16'h99AA, "R4 center waits");
        tick(16'h000F);
        chk_chan(16'h4243, "R4 center update");

        // R6 control write clears write latch
        clk_sel = 2'b00; mode = 2'b01;
        wr(1, 8'hEE);
        ctl();
        wr(0, 8'h01);
        chk_chan(16'h4243, "R6 half cleared");
        wr(1, 8'hF0);
        chk_chan(16'hF001, "R6 fresh pair");

        // R7 capture ignores writes
        mode = 2'b00;
        wr(1, 8'h10); wr(0, 8'h20);
        chk_chan(16'hF001, "R7 capture writes ignored");
        mode = 2'b01;
        wr(0, 8'h30);
        chk_chan(16'hF001, "R7 no half left from capture");
        wr(1, 8'h40);
        chk_chan(16'h4030, "R7 normal after capture");

        // R8 debug direct writes
        wr(1, 8'h61);
        freeze = 1;
        wr(0, 8'h99);
        chk_chan(16'h4099, "R8 direct low write");
        wr(1, 8'h5A);
        chk_chan(16'h5A99, "R8 direct high write");
        freeze = 0;
        step();
        wr(0, 8'h62);
        chk_chan(16'h6162, "R8 resumed sequence uses buffered high");

        // R9 read coherence
        rd(1, 8'h61, "R9 first read high");
        wr(1, 8'h70); wr(0, 8'h71);
        chk_chan(16'h7071, "R9 value changed");
        rd(0, 8'h62, "R9 snapshot low");
        rd(0, 8'h71, "R9 released, live low");
        wr(1, 8'h80); wr(0, 8'h81);
        rd(1, 8'h70, "R9 snapshot high");

        // R10 debug reads
        rd(1, 8'h80, "R10 arm before freeze");
        freeze = 1;
        wr(0, 8'h90);
        rd(0, 8'h90, "R10 live read in freeze");
        freeze = 0;
        step();
        rd(0, 8'h81, "R10 snapshot kept over freeze");

        // R6 control write clears read latch
        rd(1, 8'h80, "R6 arm read latch");
        wr(1, 8'hA0); wr(0, 8'hA1);
        ctl();
        rd(0, 8'hA1, "R6 read latch cleared");

        step();
        wait (sb_q.size() == 0);
        #3;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule